// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight level-sensitive interrupt lines and forwards the most urgent one to a host processor. It keeps three register sets: the pending set, captured from the lines one cycle after they move; the blocking set, which software writes; and the in-service set, which records the lines the host has taken and not yet retired. A combinational priority picker compares unmasked pending lines against the in-service lines, and the registered interrupt output rises only when a request is allowed to preempt.

The host programs the block through a byte-wide write port that has a command address and a data address. A start word on the command address begins a short setup sequence. The data-address writes that follow supply the upper vector bits, an optional map of which lines have downstream controllers, and an optional extra word. After setup, data writes update the blocking set, and command writes retire in-service lines, change the priority order or switch the special mask mode on and off. When the host acknowledges, the block places a vector on its output for one cycle. The vector is made of five programmed bits followed by the line number. When the block acts as head of a cascade, it also drives the line number on three cascade address lines.

Top module: `prio_intc`

## Requirements
- R1: After reset, and at all times before setup is complete, `int_out`, `vec_valid` and `cas_out` are 0, whatever the lines do.
- R2: A command-address write with bit 4 = 1 starts setup. Its bit 1 = 1 selects stand-alone operation, which skips the map word. Its bit 0 = 1 means an extra word follows. The data writes that follow are taken in this order: vector base (bits 7:3), then the map (cascaded only), then the extra word (only if requested; its bit 2 = 1 selects head of cascade, and the default is head). Every data write after that replaces the blocking set. Starting setup clears the blocking set, the in-service set, the special mask mode and the rotation.
- R3: An unblocked line that goes high while nothing is in service drives `int_out` high on the second rising edge after the change.
- R4: A blocking-set bit of 1 stops its line from raising `int_out` and from winning an acknowledge.
- R5: With the default order, line 0 is most urgent and line 7 least. The vector is {base[4:0], line[2:0]}.
- R6: A one-cycle `inta` makes `vec_valid` high for exactly the following cycle, with the winner's vector, and puts the winner into service.
- R7: Outside special mask mode, `int_out` is raised only for a request that is more urgent than every in-service line.
- R8: Command byte 001_0_0_xxx retires the most urgent in-service line.
- R9: Command byte 011_0_0_lll retires line lll.
- R10: Command byte 101_0_0_xxx retires the most urgent in-service line and makes it least urgent. Command byte 111_0_0_lll does the same for line lll. Command byte 110_0_0_lll makes line lll least urgent. In each case, the lines that follow it in wrap-around order come first.
- R11: Command byte x11_0_1_xxx turns special mask mode on, and x10_0_1_xxx turns it off. While the mode is on, any unblocked pending line that is not itself in service raises `int_out` and can win.
- R12: `cas_out` equals the winner's line number while `vec_valid` is high, if the block is cascaded, is head of the cascade, and has the winner's map bit set. Otherwise `cas_out` is 0.
- R13: An acknowledge with no eligible request gives vector {base, 7} and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| sel_cmd | input | 1 | 1 = command address, 0 = data address |
| wr_data | input | 8 | Write byte |
| irq_in | input | 8 | Level request lines |
| inta | input | 1 | Acknowledge pulse from the host |
| int_out | output | 1 | Interrupt request to the host |
| vec_valid | output | 1 | Vector present this cycle |
| vec_out | output | 8 | Vector byte |
| cas_out | output | 3 | Cascade address lines |

## Verification
The bench builds the block with its default eight lines and an eight-bit vector, so every line number fits the three cascade lines and the full wrap-around of the rotation can be reached. It first uses the cascaded setup with an extra word and map bits 2 and 3. Later it starts setup again in stand-alone form with no extra word, which reaches both skip paths of the setup sequence and the zero-cascade case.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_BASE,
        SEQ_MAP,
        SEQ_EXTRA,
        SEQ_RUN
    } seq_t;

    localparam logic [2:0] OP_EOI_ANY = 3'b001;
    localparam logic [2:0] OP_EOI_LVL = 3'b011;
    localparam logic [2:0] OP_ROT_ANY = 3'b101;
    localparam logic [2:0] OP_ROT_LVL = 3'b111;
    localparam logic [2:0] OP_SET_LOW = 3'b110;

    localparam logic [1:0] SM_ON  = 2'b11;
    localparam logic [1:0] SM_OFF = 2'b10;

    typedef struct packed {
        logic             eoi;
        logic             by_level;
        logic             rotate;
        logic             set_low;
        logic [BUS_W-1:0] raw;
    } cmd_t;

    function automatic logic is_setup_start(input logic [BUS_W-1:0] d);
        return d[4];
    endfunction

endpackage

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [LW-1:0] low,
    output logic          found,
    output logic [LW-1:0] lvl,
    output logic [LW-1:0] rank
);
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(low) + 1 + i) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                lvl   = LW'(idx);
                rank  = LW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc_cfg.sv
module prio_intc_cfg
    import prio_intc_pkg::*;
#(
    parameter int N      = 8,
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sel_cmd,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              ready,
    output logic [BASE_W-1:0] base,
    output logic [N-1:0]      slave_map,
    output logic              master,
    output logic              cascaded,
    output logic [N-1:0]      mask,
    output logic              smm,
    output logic              init_pulse,
    output cmd_t              cmd
);
    seq_t seq;
    logic need_extra;

    assign ready = (seq == SEQ_RUN);

    always_ff @(posedge clk) begin
        init_pulse <= 1'b0;
        cmd        <= '0;
        if (rst) begin
            seq        <= SEQ_OFF;
            base       <= '0;
            slave_map  <= '0;
            master     <= 1'b1;
            cascaded   <= 1'b0;
            need_extra <= 1'b0;
            mask       <= '0;
            smm        <= 1'b0;
        end else if (wr_en) begin
            if (sel_cmd && is_setup_start(wr_data)) begin
                seq        <= SEQ_BASE;
                cascaded   <= ~wr_data[1];
                need_extra <= wr_data[0];
                master     <= 1'b1;
                slave_map  <= '0;
                mask       <= '0;
                smm        <= 1'b0;
                init_pulse <= 1'b1;
            end else if (sel_cmd) begin
                if (seq == SEQ_RUN) begin
                    if (!wr_data[3]) begin
                        cmd.raw <= wr_data;
                        case (wr_data[7:5])
                            OP_EOI_ANY: cmd.eoi <= 1'b1;
                            OP_EOI_LVL: begin
                                cmd.eoi      <= 1'b1;
                                cmd.by_level <= 1'b1;
                            end
                            OP_ROT_ANY: begin
                                cmd.eoi    <= 1'b1;
                                cmd.rotate <= 1'b1;
                            end
                            OP_ROT_LVL: begin
                                cmd.eoi      <= 1'b1;
                                cmd.by_level <= 1'b1;
                                cmd.rotate   <= 1'b1;
                            end
                            OP_SET_LOW: cmd.set_low <= 1'b1;
                            default: ;
                        endcase
                    end else if (wr_data[6:5] == SM_ON) begin
                        smm <= 1'b1;
                    end else if (wr_data[6:5] == SM_OFF) begin
                        smm <= 1'b0;
                    end
                end
            end else begin
                case (seq)
                    SEQ_BASE: begin
                        base <= wr_data[BUS_W-1 -: BASE_W];
                        if (cascaded)        seq <= SEQ_MAP;
                        else if (need_extra) seq <= SEQ_EXTRA;
                        else                 seq <= SEQ_RUN;
                    end
                    SEQ_MAP: begin
                        slave_map <= wr_data[N-1:0];
                        seq       <= need_extra ? SEQ_EXTRA : SEQ_RUN;
                    end
                    SEQ_EXTRA: begin
                        master <= wr_data[2];
                        seq    <= SEQ_RUN;
                    end
                    SEQ_RUN: mask <= wr_data[N-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       sel_cmd,
    input  logic [BUS_W-1:0]           wr_data,
    input  logic [N_LINES-1:0]         irq_in,
    input  logic                       inta,
    output logic                       int_out,
    output logic                       vec_valid,
    output logic [VEC_W-1:0]           vec_out,
    output logic [$clog2(N_LINES)-1:0] cas_out
);
    localparam int LVL_W  = $clog2(N_LINES);
    localparam int BASE_W = VEC_W - LVL_W;

    logic              ready, master, cascaded, smm, init_pulse;
    logic [BASE_W-1:0] base;
    logic [N_LINES-1:0] slave_map, mask;
    cmd_t              cmd;

    prio_intc_cfg #(.N(N_LINES), .BASE_W(BASE_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel_cmd(sel_cmd), .wr_data(wr_data),
        .ready(ready), .base(base), .slave_map(slave_map), .master(master),
        .cascaded(cascaded), .mask(mask), .smm(smm), .init_pulse(init_pulse), .cmd(cmd)
    );

    logic [N_LINES-1:0] irr, isr, isr_n, pend, pend_free;
    logic [LVL_W-1:0]   low;

    assign pend      = irr & ~mask;
    assign pend_free = pend & ~isr;

    logic             pend_found, free_found, isr_found;
    logic [LVL_W-1:0] pend_lvl, free_lvl, isr_lvl;
    logic [LVL_W-1:0] pend_rank, free_rank, isr_rank;

    prio_intc_pick #(.N(N_LINES), .LW(LVL_W)) u_pick_pend (
        .req(pend), .low(low), .found(pend_found), .lvl(pend_lvl), .rank(pend_rank));
    prio_intc_pick #(.N(N_LINES), .LW(LVL_W)) u_pick_free (
        .req(pend_free), .low(low), .found(free_found), .lvl(free_lvl), .rank(free_rank));
    prio_intc_pick #(.N(N_LINES), .LW(LVL_W)) u_pick_isr (
        .req(isr), .low(low), .found(isr_found), .lvl(isr_lvl), .rank(isr_rank));

    logic             grant_ok;
    logic [LVL_W-1:0] grant_lvl;
    logic             tgt_ok;
    logic [LVL_W-1:0] tgt_lvl;

    always_comb begin
        if (smm) begin
            grant_ok  = ready && free_found;
            grant_lvl = free_lvl;
        end else begin
            grant_ok  = ready && pend_found && (!isr_found || (pend_rank < isr_rank));
            grant_lvl = pend_lvl;
        end
        tgt_lvl = cmd.by_level ? cmd.raw[LVL_W-1:0] : isr_lvl;
        tgt_ok  = cmd.eoi && (cmd.by_level || isr_found);
        isr_n = isr;
        if (tgt_ok)          isr_n[tgt_lvl]   = 1'b0;
        if (inta && grant_ok) isr_n[grant_lvl] = 1'b1;
        if (init_pulse)      isr_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr       <= '0;
            isr       <= '0;
            low       <= '1;
            int_out   <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
            cas_out   <= '0;
        end else begin
            irr       <= irq_in;
            isr       <= isr_n;
            int_out   <= grant_ok;
            vec_valid <= inta;
            cas_out   <= '0;
            if (inta) begin
                vec_out <= {base, grant_ok ? grant_lvl : {LVL_W{1'b1}}};
                if (grant_ok && master && cascaded && slave_map[grant_lvl])
                    cas_out <= grant_lvl;
            end
            if (init_pulse)                low <= '1;
            else if (cmd.set_low)          low <= cmd.raw[LVL_W-1:0];
            else if (tgt_ok && cmd.rotate) low <= tgt_lvl;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       inta,
    input logic                       int_out,
    input logic                       vec_valid,
    input logic [VEC_W-1:0]           vec_out,
    input logic [$clog2(N_LINES)-1:0] cas_out,
    input logic                       ready,
    input logic [VEC_W-$clog2(N_LINES)-1:0] base,
    input logic [N_LINES-1:0]         isr,
    input logic                       grant_ok,
    input logic [$clog2(N_LINES)-1:0] grant_lvl,
    input logic                       init_pulse
);
    localparam int LVL_W = $clog2(N_LINES);

    AST_NO_INT_UNSET: assert property (@(posedge clk) disable iff (rst)
        !ready |=> !int_out) else $error("int without setup"); // R1

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta)) else $error("vector without ack"); // R6

    AST_ISR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (inta && grant_ok && !init_pulse) |=> isr[$past(grant_lvl)]) else $error("ack not in service"); // R6

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $stable(base)) |-> (vec_out[VEC_W-1:LVL_W] == base)) else $error("vector base"); // R5

    AST_CAS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (cas_out == '0)) else $error("cascade lines busy"); // R12
endmodule

bind prio_intc prio_intc_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .inta(inta), .int_out(int_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .cas_out(cas_out), .ready(ready), .base(base), .isr(isr),
    .grant_ok(grant_ok), .grant_lvl(grant_lvl), .init_pulse(init_pulse)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic       clk = 1'b0;
    logic       rst, wr_en, sel_cmd, inta;
    logic [7:0] wr_data, irq_in;
    logic       int_out, vec_valid;
    logic [7:0] vec_out;
    logic [2:0] cas_out;

    int checks = 0;
    int errors = 0;
    logic       got_vv;
    logic [7:0] got_vec;
    logic [2:0] got_cas;

    always #10 clk = ~clk;

    prio_intc dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel_cmd(sel_cmd), .wr_data(wr_data),
        .irq_in(irq_in), .inta(inta), .int_out(int_out), .vec_valid(vec_valid),
        .vec_out(vec_out), .cas_out(cas_out)
    );

    // irq[16:9], expected int [8], expected vector [7:0]; base 10101
    localparam logic [16:0] TBL [6] = '{
        {8'h01, 1'b1, 8'hA8},
        {8'h80, 1'b1, 8'hAF},
        {8'h28, 1'b1, 8'hAB},
        {8'hF0, 1'b1, 8'hAC},
        {8'h00, 1'b0, 8'hAF},
        {8'h06, 1'b1, 8'hA9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic cmd, input logic [7:0] d);
        wr_en = 1'b1; sel_cmd = cmd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; sel_cmd = 1'b0; wr_data = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        got_vv = vec_valid; got_vec = vec_out; got_cas = cas_out;
        @(negedge clk);
        check("R6 vec_valid one cycle", {31'd0, vec_valid}, 32'd0);
    endtask

    task automatic irq_int(input logic [7:0] v, input logic exp, input string tag);
        irq_in = v;
        settle();
        check(tag, {31'd0, int_out}, {31'd0, exp});
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; sel_cmd = 0; wr_data = 0; irq_in = 0; inta = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset int", {31'd0, int_out}, 32'd0);
        check("R1 reset vec_valid", {31'd0, vec_valid}, 32'd0);
        check("R1 reset cas", {29'd0, cas_out}, 32'd0);
        irq_int(8'h01, 1'b0, "R1 no int before setup");
        irq_in = 0;

        // R2 cascaded setup with extra word: base A8, map 0C, head of cascade
        wr(1, 8'h11); wr(0, 8'hA8); wr(0, 8'h0C); wr(0, 8'h04);
        settle();

        for (int i = 0; i < 6; i++) begin
            irq_int(TBL[i][16:9], TBL[i][8], "R3/R5 table int");
            ack();
            check(TBL[i][8] ? "R5 table vector" : "R13 spurious vector",
                  {24'd0, got_vec}, {24'd0, TBL[i][7:0]});
            check("R6 table vec_valid", {31'd0, got_vv}, 32'd1);
            irq_in = 0;
            wr(1, 8'h20);
            settle();
        end
        irq_int(8'h00, 1'b0, "R13 in-service unchanged after spurious");

        // R4 mask
        wr(0, 8'h01);
        irq_int(8'h01, 1'b0, "R4 masked line");
        irq_int(8'h03, 1'b1, "R4 other line");
        ack();
        check("R4 masked loses", {24'd0, got_vec}, 32'hA9);
        irq_in = 0; wr(1, 8'h20); wr(0, 8'h00); settle();

        // R7 nesting, R12 cascade
        irq_in = 8'h08; settle(); ack();
        check("R12 cas on mapped line", {29'd0, got_cas}, 32'd3);
        irq_int(8'h20, 1'b0, "R7 lower blocked");
        irq_int(8'h22, 1'b1, "R7 higher preempts");
        ack();
        check("R7 nested vector", {24'd0, got_vec}, 32'hA9);
        check("R12 cas zero on unmapped line", {29'd0, got_cas}, 32'd0);
        irq_in = 0; settle();
        wr(1, 8'h20); settle();                       // R8 retires line 1
        irq_int(8'h02, 1'b1, "R8 most urgent retired");
        irq_int(8'h20, 1'b0, "R8 line 3 still in service");
        irq_in = 0; settle();
        wr(1, 8'h63); settle();                       // R9 retire line 3
        irq_int(8'h20, 1'b1, "R9 specific retire");
        irq_in = 0; settle();

        // R10 rotation
        irq_in = 8'h04; settle(); ack(); irq_in = 0; settle();
        wr(1, 8'hA0); settle();
        irq_in = 8'h14; settle(); ack();
        check("R10 rotate on retire", {24'd0, got_vec}, 32'hAC);
        irq_in = 0; wr(1, 8'h20); settle();
        wr(1, 8'hC5); settle();
        irq_in = 8'h41; settle(); ack();
        check("R10 set lowest", {24'd0, got_vec}, 32'hAE);
        irq_in = 0; wr(1, 8'h20); settle();
        irq_in = 8'h20; settle(); ack(); irq_in = 0; settle();
        wr(1, 8'hE5); settle();
        irq_in = 8'h81; settle(); ack();
        check("R10 specific rotate", {24'd0, got_vec}, 32'hAF);
        irq_in = 0; wr(1, 8'h20); wr(1, 8'hC7); settle();

        // R11 special mask mode
        irq_in = 8'h08; settle(); ack(); irq_in = 0; settle();
        wr(1, 8'h68);
        irq_int(8'h20, 1'b1, "R11 lower served in special mode");
        ack();
        check("R11 vector", {24'd0, got_vec}, 32'hAD);
        irq_int(8'h08, 1'b0, "R11 own line stays blocked");
        irq_in = 0; wr(1, 8'h48); wr(1, 8'h20); wr(1, 8'h20); settle();
        irq_int(8'h20, 1'b1, "R11 cleared after retire");
        irq_in = 0; settle();

        // R2 stand-alone setup, no extra word
        wr(1, 8'h12); wr(0, 8'h40); wr(0, 8'hFE); settle();
        irq_int(8'h02, 1'b0, "R2 data write after base is mask");
        irq_int(8'h03, 1'b1, "R2 unmasked line");
        ack();
        check("R2 new base", {24'd0, got_vec}, 32'h40);
        check("R12 stand-alone cas", {29'd0, got_cas}, 32'd0);
        irq_in = 0; settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule